// File: doc/BRIEF.md
# Quadrature Up/Down Counter

This block keeps a signed position count driven by two count inputs (A and B) and a third input that acts either as a zero marker or as a push-button. Every input first passes through its own debounce filter, whose length is set by a shared input. A mode input chooses how A and B are turned into count steps: Gray-coded quadrature, plain 2-bit binary code, a count clock on A with direction taken from the level of B, or separate up (A) and down (B) edge inputs.

After each step the new value is compared against a programmable upper and lower bound. Crossing a bound pulses a warning output for that side, and in auto-zero mode it also forces the count to zero. Each accepted step pulses a count-event output with the step's direction, so an external timer can measure the time between events. Illegal code jumps are reported on their own output and never move the count.

Top module: `qdc_counter`

## Requirements
- R1: After reset the count is 0 and countEvent, quadErr, upperHit, lowerHit and buttonEvent are all low.
- R2: With mode = 0 (quadrature), the filtered pair {A,B} stepping 00→01→11→10→00 adds 1 per step and the reverse order subtracts 1. Each step pulses countEvent for one cycle, with dirUp = 1 for up and 0 for down.
- R3: In modes 0 and 1, a step that moves the decoded 2-bit position by two (in quadrature, both A and B changing together) leaves the count unchanged, pulses quadErr and raises no countEvent.
- R4: A filtered input takes a new raw level only after that level has been seen on dbLen+1 consecutive clock edges. A shorter pulse causes no event and no count change. The count updates one edge after the filtered level does.
- R5: With mode = 1 (binary), {A,B} is read as an unsigned 2-bit number. A change of +1 modulo 4 counts up and a change of −1 modulo 4 counts down.
- R6: When a step makes the count greater than upperBound (signed), upperHit pulses with the step. When it makes the count less than lowerBound, lowerHit pulses. With boundMode = 0 the count keeps the stepped value.
- R7: With boundMode = 1, a step that crosses either bound sets the count to 0. The matching hit output and countEvent still pulse.
- R8: A rising edge of the filtered zero input clears the count to 0 without countEvent when zeroClrEn = 1. When zeroClrEn = 0, the same edge pulses buttonEvent and leaves the count unchanged. A falling edge does nothing.
- R9: With mode = 2, each rising edge of filtered A counts up if filtered B is 1 and down if it is 0. Falling edges of A and any change of B do not count.
- R10: With mode = 3, a rising edge of A counts up and a rising edge of B counts down. Both rising on the same edge, or any falling edge, leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pinA | input | 1 | Raw count input A |
| pinB | input | 1 | Raw count input B |
| pinZ | input | 1 | Raw zero-marker / push-button input |
| mode | input | 2 | 0 quadrature, 1 binary, 2 level direction, 3 up/down edges |
| dbLen | input | DB_W (8) | Debounce length |
| zeroClrEn | input | 1 | 1: zero edge clears count; 0: zero edge is a button event |
| boundMode | input | 1 | 1: auto-zero on bound crossing |
| upperBound | input | CNT_W (32) | Signed upper bound |
| lowerBound | input | CNT_W (32) | Signed lower bound |
| count | output | CNT_W (32) | Signed position count |
| countEvent | output | 1 | One-cycle pulse per accepted step |
| dirUp | output | 1 | Direction of the last step |
| upperHit | output | 1 | Pulse: step went above upperBound |
| lowerHit | output | 1 | Pulse: step went below lowerBound |
| quadErr | output | 1 | Pulse: illegal code jump |
| buttonEvent | output | 1 | Pulse: zero-input rising edge in button use |

## Verification
On every cycle, the assertions check four things:
- a count event moves the count by exactly one unless a bound was crossed;
- an illegal jump never moves the count and never coincides with an event;
- a bound hit only ever comes with an event;
- in auto-zero mode, a hit leaves the count at zero.

The bench scenarios show the rest:
- which step direction each mode derives from a given pin sequence;
- that short glitches are swallowed by the debounce filter;
- how the zero input splits between clearing and button use.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_BIN  = 2'd1,
    MODE_LVL  = 2'd2,
    MODE_EDGE = 2'd3
  } qdcMode_t;

  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic clear;
    logic badStep;
    logic button;
  } qdcStrobe_t;
endpackage

// File: rtl/qdc_filter.sv
module qdc_filter #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw,
  input  logic [DB_W-1:0] len,
  output logic            level
);
  logic [DB_W-1:0] stableCnt;

  // Take the new level only after it has been held for len+1 edges.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level     <= 1'b0;
      stableCnt <= '0;
    end else if (raw == level) begin
      stableCnt <= '0;
    end else if (stableCnt == len) begin
      level     <= raw;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end
endmodule

// File: rtl/qdc_ctrl.sv
module qdc_ctrl
  import qdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fA,
  input  logic       fB,
  input  logic       fZ,
  input  logic [1:0] mode,
  input  logic       zeroClrEn,
  output qdcStrobe_t strb
);
  logic prevA, prevB, prevZ;
  logic [1:0] curPos, prevPos, delta;
  logic aRise, bRise, zRise;
  logic up, dn, bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
      prevZ <= 1'b0;
    end else begin
      prevA <= fA;
      prevB <= fB;
      prevZ <= fZ;
    end
  end

  always_comb begin
    // In quadrature mode, convert the Gray pair to a binary position first.
    if (qdcMode_t'(mode) == MODE_QUAD) begin
      curPos  = {fA, fA ^ fB};
      prevPos = {prevA, prevA ^ prevB};
    end else begin
      curPos  = {fA, fB};
      prevPos = {prevA, prevB};
    end
    delta = curPos - prevPos;
    aRise = fA & ~prevA;
    bRise = fB & ~prevB;
    zRise = fZ & ~prevZ;
    up  = 1'b0;
    dn  = 1'b0;
    bad = 1'b0;
    case (qdcMode_t'(mode))
      MODE_QUAD, MODE_BIN: begin
        up  = (delta == 2'd1);
        dn  = (delta == 2'd3);
        bad = (delta == 2'd2);
      end
      MODE_LVL: begin
        up = aRise & fB;
        dn = aRise & ~fB;
      end
      default: begin
        up = aRise & ~bRise;
        dn = bRise & ~aRise;
      end
    endcase
    strb.clear   = zRise & zeroClrEn;
    strb.button  = zRise & ~zeroClrEn;
    // A clear on the same edge takes priority and drops the step.
    strb.stepUp  = up & ~strb.clear;
    strb.stepDn  = dn & ~strb.clear;
    strb.badStep = bad;
  end
endmodule

// File: rtl/qdc_datapath.sv
module qdc_datapath
  import qdc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qdcStrobe_t       strb,
  input  logic [CNT_W-1:0] upperBound,
  input  logic [CNT_W-1:0] lowerBound,
  input  logic             boundMode,
  output logic [CNT_W-1:0] count,
  output logic             countEvent,
  output logic             dirUp,
  output logic             upperHit,
  output logic             lowerHit,
  output logic             quadErr,
  output logic             buttonEvent
);
  logic [CNT_W-1:0] stepped;
  logic overUp, underLo, doStep;

  always_comb begin
    doStep  = strb.stepUp | strb.stepDn;
    stepped = strb.stepUp ? count + 1'b1 : count - 1'b1;
    overUp  = $signed(stepped) > $signed(upperBound);
    underLo = $signed(stepped) < $signed(lowerBound);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count       <= '0;
      countEvent  <= 1'b0;
      dirUp       <= 1'b0;
      upperHit    <= 1'b0;
      lowerHit    <= 1'b0;
      quadErr     <= 1'b0;
      buttonEvent <= 1'b0;
    end else begin
      countEvent  <= doStep;
      upperHit    <= doStep & overUp;
      lowerHit    <= doStep & underLo;
      quadErr     <= strb.badStep;
      buttonEvent <= strb.button;
      if (strb.clear) begin
        count <= '0;
      end else if (doStep) begin
        dirUp <= strb.stepUp;
        count <= (boundMode && (overUp || underLo)) ? '0 : stepped;
      end
    end
  end
endmodule

// File: rtl/qdc_counter.sv
module qdc_counter
  import qdc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DB_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pinA,
  input  logic             pinB,
  input  logic             pinZ,
  input  logic [1:0]       mode,
  input  logic [DB_W-1:0]  dbLen,
  input  logic             zeroClrEn,
  input  logic             boundMode,
  input  logic [CNT_W-1:0] upperBound,
  input  logic [CNT_W-1:0] lowerBound,
  output logic [CNT_W-1:0] count,
  output logic             countEvent,
  output logic             dirUp,
  output logic             upperHit,
  output logic             lowerHit,
  output logic             quadErr,
  output logic             buttonEvent
);
  localparam int N_PINS = 3;

  logic [N_PINS-1:0] rawPins, filtPins;
  qdcStrobe_t strb;

  assign rawPins = {pinZ, pinB, pinA};

  for (genvar i = 0; i < N_PINS; i++) begin : g_filt
    qdc_filter #(.DB_W(DB_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(rawPins[i]), .len(dbLen), .level(filtPins[i])
    );
  end

  qdc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fA(filtPins[0]), .fB(filtPins[1]), .fZ(filtPins[2]),
    .mode(mode), .zeroClrEn(zeroClrEn), .strb(strb)
  );

  qdc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .upperBound(upperBound),
    .lowerBound(lowerBound), .boundMode(boundMode), .count(count),
    .countEvent(countEvent), .dirUp(dirUp), .upperHit(upperHit),
    .lowerHit(lowerHit), .quadErr(quadErr), .buttonEvent(buttonEvent)
  );
endmodule

// File: rtl/qdc_counter_checker.sv
module qdc_counter_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundMode,
  input logic [CNT_W-1:0] count,
  input logic             countEvent,
  input logic             upperHit,
  input logic             lowerHit,
  input logic             quadErr
);
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (countEvent && !upperHit && !lowerHit) |->
      ((count == $past(count) + 1'b1) || (count == $past(count) - 1'b1)));

  p_bad_no_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quadErr |-> (!countEvent && ((count == $past(count)) || (count == '0))));

  p_hit_with_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upperHit || lowerHit) |-> countEvent);

  p_autozero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((upperHit || lowerHit) && $past(boundMode)) |-> (count == '0));
endmodule

bind qdc_counter qdc_counter_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundMode(boundMode), .count(count),
  .countEvent(countEvent), .upperHit(upperHit), .lowerHit(lowerHit), .quadErr(quadErr)
);

// File: tb/qdc_counter_test.sv
module qdc_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pinA = 1'b0, pinB = 1'b0, pinZ = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] dbLen = 8'd2;
  logic zeroClrEn = 1'b1, boundMode = 1'b0;
  logic [31:0] upperBound = 32'sd5, lowerBound = -32'sd5;
  logic [31:0] count;
  logic countEvent, dirUp, upperHit, lowerHit, quadErr, buttonEvent;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] cnt;
    logic dir, evt, err, hu, hl, btn;
  } exp_t;
  exp_t expQ[$];
  string tagQ[$];

  always #2.5 clk = ~clk;

  qdc_counter uut (
    .clk(clk), .rst_n(rst_n), .pinA(pinA), .pinB(pinB), .pinZ(pinZ), .mode(mode),
    .dbLen(dbLen), .zeroClrEn(zeroClrEn), .boundMode(boundMode),
    .upperBound(upperBound), .lowerBound(lowerBound), .count(count),
    .countEvent(countEvent), .dirUp(dirUp), .upperHit(upperHit),
    .lowerHit(lowerHit), .quadErr(quadErr), .buttonEvent(buttonEvent)
  );

  task automatic expect_item(input int cnt, input bit dir, input bit evt, input bit err,
                             input bit hu, input bit hl, input bit btn, input string tag);
    exp_t e;
    e.cnt = cnt; e.dir = dir; e.evt = evt; e.err = err; e.hu = hu; e.hl = hl; e.btn = btn;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic drive(input bit a, input bit b, input bit z);
    @(negedge clk);
    pinA = a; pinB = b; pinZ = z;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_count(input int exp, input string tag);
    checks++;
    if (count !== exp) begin
      fails++;
      $display("FAIL %s count actual=%0d expected=%0d", tag, $signed(count), exp);
    end
  endtask

  // Monitor: every output pulse is matched against the next expected item.
  always @(negedge clk) begin
    if (rst_n && !done && (countEvent | quadErr | upperHit | lowerHit | buttonEvent)) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected pulse actual evt=%b err=%b hu=%b hl=%b btn=%b count=%0d expected none",
                 countEvent, quadErr, upperHit, lowerHit, buttonEvent, $signed(count));
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (count !== e.cnt || countEvent !== e.evt || quadErr !== e.err ||
            upperHit !== e.hu || lowerHit !== e.hl || buttonEvent !== e.btn ||
            (e.evt && dirUp !== e.dir)) begin
          fails++;
          $display("FAIL %s actual cnt=%0d dir=%b evt=%b err=%b hu=%b hl=%b btn=%b expected cnt=%0d dir=%b evt=%b err=%b hu=%b hl=%b btn=%b",
                   t, $signed(count), dirUp, countEvent, quadErr, upperHit, lowerHit, buttonEvent,
                   $signed(e.cnt), e.dir, e.evt, e.err, e.hu, e.hl, e.btn);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (count !== 0 || countEvent || quadErr || upperHit || lowerHit || buttonEvent) begin
      fails++;
      $display("FAIL R1 reset actual count=%0d pulses=%b%b%b%b%b expected 0 and 00000", $signed(count),
               countEvent, quadErr, upperHit, lowerHit, buttonEvent);
    end

    // R2 quadrature, up then down
    expect_item(1, 1, 1, 0, 0, 0, 0, "R2"); drive(0, 1, 0);
    expect_item(2, 1, 1, 0, 0, 0, 0, "R2"); drive(1, 1, 0);
    expect_item(3, 1, 1, 0, 0, 0, 0, "R2"); drive(1, 0, 0);
    expect_item(4, 1, 1, 0, 0, 0, 0, "R2"); drive(0, 0, 0);
    expect_item(3, 0, 1, 0, 0, 0, 0, "R2"); drive(1, 0, 0);
    // R3 both pins change together
    expect_item(3, 0, 0, 1, 0, 0, 0, "R3"); drive(0, 1, 0);
    // R4 glitch of two cycles on A is filtered out
    @(negedge clk); pinA = 1'b1;
    repeat (2) @(negedge clk); pinA = 1'b0;
    repeat (8) @(negedge clk);
    check_count(3, "R4");

    // R6 warning on upper bound only
    expect_item(4, 1, 1, 0, 0, 0, 0, "R6"); drive(1, 1, 0);
    expect_item(5, 1, 1, 0, 0, 0, 0, "R6"); drive(1, 0, 0);
    expect_item(6, 1, 1, 0, 1, 0, 0, "R6"); drive(0, 0, 0);
    // R7 auto-zero on upper
    boundMode = 1'b1;
    expect_item(0, 1, 1, 0, 1, 0, 0, "R7"); drive(0, 1, 0);
    // R7 auto-zero on lower
    lowerBound = -32'sd2;
    expect_item(-1, 0, 1, 0, 0, 0, 0, "R7"); drive(0, 0, 0);
    expect_item(-2, 0, 1, 0, 0, 0, 0, "R7"); drive(1, 0, 0);
    expect_item(0, 0, 1, 0, 0, 1, 0, "R7"); drive(1, 1, 0);
    expect_item(-1, 0, 1, 0, 0, 0, 0, "R2"); drive(0, 1, 0);

    // R8 zero marker clear, then button use
    drive(0, 1, 1);
    check_count(0, "R8");
    drive(0, 1, 0);
    zeroClrEn = 1'b0;
    expect_item(0, 0, 0, 0, 0, 0, 1, "R8"); drive(0, 1, 1);
    drive(0, 1, 0);
    check_count(0, "R8");

    // R5 binary mode
    upperBound = 32'sd100; lowerBound = -32'sd100; boundMode = 1'b0; mode = 2'd1;
    expect_item(1, 1, 1, 0, 0, 0, 0, "R5"); drive(1, 0, 0);
    expect_item(2, 1, 1, 0, 0, 0, 0, "R5"); drive(1, 1, 0);
    expect_item(3, 1, 1, 0, 0, 0, 0, "R5"); drive(0, 0, 0);
    expect_item(3, 1, 0, 1, 0, 0, 0, "R3"); drive(1, 0, 0);
    expect_item(2, 0, 1, 0, 0, 0, 0, "R5"); drive(0, 1, 0);

    // R9 level direction mode
    mode = 2'd2;
    expect_item(3, 1, 1, 0, 0, 0, 0, "R9"); drive(1, 1, 0);
    drive(0, 1, 0);
    drive(0, 0, 0);
    expect_item(2, 0, 1, 0, 0, 0, 0, "R9"); drive(1, 0, 0);
    drive(0, 0, 0);
    check_count(2, "R9");

    // R10 separate up/down edges
    mode = 2'd3;
    expect_item(3, 1, 1, 0, 0, 0, 0, "R10"); drive(1, 0, 0);
    drive(0, 0, 0);
    expect_item(2, 0, 1, 0, 0, 0, 0, "R10"); drive(0, 1, 0);
    drive(0, 0, 0);
    drive(1, 1, 0);
    check_count(2, "R10");
    drive(0, 0, 0);

    // R4 with zero debounce length a single-cycle pulse counts
    dbLen = 8'd0;
    expect_item(3, 1, 1, 0, 0, 0, 0, "R4");
    @(negedge clk); pinA = 1'b1;
    @(negedge clk); pinA = 1'b0;
    repeat (8) @(negedge clk);
    check_count(3, "R4");

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R4 missing pulses actual=%0d pending expected 0", expQ.size());
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule